// File: doc/BRIEF.md
# Moving-Average Threshold Peak Detector

This block watches a stream of signed samples and keeps the mean of the four most recently accepted values. When that mean rises strictly above a threshold supplied on an input port, a registered alert flag goes high. The alert is re-evaluated only when a fresh mean is complete, and it keeps its value in between.

The four-term sum is not built by a tree of adders. A single two-input adder is shared over four clock cycles. A small sequencer with a tap counter steps through the stored window, adding one entry per cycle into an accumulator that is cleared first. While the accumulation runs, the block holds `ready` low and ignores any strobe on `smp_valid`. Dividing by four is done as an arithmetic right shift by two bits, which rounds toward negative infinity. The accumulator carries two guard bits, so the sum never overflows.

Top module: `movavg_peak_det`

## Requirements
- R1: After the synchronous active-low reset, `ready` is 1, `avg_out` is 0 and `alert` is 0, and all four stored window entries are zero.
- R2: A sample is accepted on a rising clock edge where both `smp_valid` and `ready` are 1. `ready` is then 0 for exactly four cycles, and it returns to 1 on the fourth edge after the accepting edge.
- R3: When `ready` returns to 1, `avg_out` equals the signed sum of the last four accepted samples shifted right arithmetically by 2 bits (floor division by 4, two's complement).
- R4: Until four samples have been accepted since reset, the window positions not yet filled contribute zero to the sum.
- R5: `alert` is updated in the same edge as `avg_out`. It is 1 exactly when the new average, as a signed value, is strictly greater than the signed `thresh` sampled at that edge. An average equal to the threshold gives 0.
- R6: Between two completions, `avg_out` and `alert` keep their values.
- R7: A `smp_valid` strobe while `ready` is 0 is ignored. It changes neither the window nor the result of the accumulation in progress.
- R8: Full-scale inputs cause no overflow. Four samples of the most positive value average to that value, and four of the most negative value average to that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, taken only while `ready` is high |
| smp_data | input | SAMPLE_W | Signed sample value |
| thresh | input | SAMPLE_W | Signed alert threshold, sampled at completion |
| ready | output | 1 | High when a new sample can be accepted |
| avg_out | output | SAMPLE_W | Signed mean of the last four samples |
| alert | output | 1 | Registered flag: mean strictly above threshold |

## Verification
A window entry that shifted wrongly, or a tap counter that skipped or repeated an entry, produces a wrong `avg_out` at the very next rise of `ready`. The next three averages stay wrong as well, until the bad entry has left the window, so the scoreboard compares every completion against a reference window. A sequencer that lost count shows up as a busy period on `ready` other than four cycles, and that is caught at the accepting sample. A strobe that leaks in during the busy time corrupts the following averages and is caught the same way.

// File: rtl/pd_pkg.sv
// Package: shared constants and types for the moving-average peak detector.
// Assumes a fixed four-entry window; the tap index width follows from it.
package pd_pkg;
    localparam int WIN_LEN   = 4;
    localparam int IDX_W     = $clog2(WIN_LEN);
    localparam int GUARD_W   = $clog2(WIN_LEN);

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/pd_window.sv
// Module: pd_window
// Holds the most recent WIN_LEN samples in a shift chain. Tap 0 is the newest.
// A read port selects one tap by index for the shared adder.
// Assumes shift_en is a single-cycle pulse per accepted sample.
module pd_window #(
    parameter int SAMPLE_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shift_en,
    input  logic signed [SAMPLE_W-1:0]   din,
    input  logic [pd_pkg::IDX_W-1:0]     rd_idx,
    output logic signed [SAMPLE_W-1:0]   rd_data
);
    import pd_pkg::*;

    logic signed [SAMPLE_W-1:0] taps [WIN_LEN];

    genvar gi;
    generate
        for (gi = 0; gi < WIN_LEN; gi++) begin : g_tap
            if (gi == 0) begin : g_head
                // Purpose: load the newest sample into the head tap.
                always_ff @(posedge clk) begin
                    if (!rst_n)        taps[gi] <= '0;
                    else if (shift_en) taps[gi] <= din;
                end
            end else begin : g_body
                // Purpose: move each older sample one position down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n)        taps[gi] <= '0;
                    else if (shift_en) taps[gi] <= taps[gi-1];
                end
            end
        end
    endgenerate

    // Purpose: select the tap that feeds the adder this cycle.
    always_comb begin
        rd_data = taps[rd_idx];
    end
endmodule

// File: rtl/pd_seq.sv
// Module: pd_seq
// Controller with a tap counter. In idle it accepts one sample and clears the
// accumulator. It then spends WIN_LEN cycles adding one tap per cycle, and marks
// the last one so the result can be registered. Strobes while busy are dropped.
module pd_seq (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       ready,
    output logic                       accept,
    output logic                       acc_clr,
    output logic                       acc_add,
    output logic                       acc_last,
    output logic [pd_pkg::IDX_W-1:0]   rd_idx
);
    import pd_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

    seq_state_t              state_q, state_d;
    logic [IDX_W-1:0]        idx_q,   idx_d;

    // Purpose: decode handshake and datapath controls from the current state.
    always_comb begin
        ready    = (state_q == SEQ_IDLE);
        accept   = ready && in_valid;
        acc_clr  = accept;
        acc_add  = (state_q == SEQ_RUN);
        acc_last = acc_add && (idx_q == LAST_IDX);
        rd_idx   = idx_q;
    end

    // Purpose: next-state and tap-counter logic.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SEQ_IDLE: begin
                idx_d = '0;
                if (accept) state_d = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (acc_last) begin
                    state_d = SEQ_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d   = idx_q + 1'b1;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // Purpose: state and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end
endmodule

// File: rtl/pd_accum.sv
// Module: pd_accum
// The single shared two-input adder, the accumulator, and the result registers.
// The accumulator has GUARD_W extra bits so that a sum of WIN_LEN samples fits.
// On the last add the sum is shifted right (floor divide) and compared,
// strictly, with the threshold. Assumes clr never coincides with add_en.
module pd_accum #(
    parameter int SAMPLE_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         add_en,
    input  logic                         last,
    input  logic signed [SAMPLE_W-1:0]   operand,
    input  logic signed [SAMPLE_W-1:0]   thresh,
    output logic signed [SAMPLE_W-1:0]   avg,
    output logic                         alert
);
    import pd_pkg::*;

    localparam int ACC_W = SAMPLE_W + GUARD_W;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] operand_ext;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] mean_full;
    logic signed [ACC_W-1:0] thresh_ext;
    logic                    above;

    // Purpose: the one shared adder plus the divide by shift and the compare.
    always_comb begin
        operand_ext = {{GUARD_W{operand[SAMPLE_W-1]}}, operand};
        thresh_ext  = {{GUARD_W{thresh[SAMPLE_W-1]}}, thresh};
        sum         = acc_q + operand_ext;
        mean_full   = sum >>> GUARD_W;
        above       = (mean_full > thresh_ext);
    end

    // Purpose: accumulator register, cleared per sample, loaded per add.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr)    acc_q <= '0;
        else if (add_en) acc_q <= sum;
    end

    // Purpose: register the average and the alert on completion only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg   <= '0;
            alert <= 1'b0;
        end else if (last) begin
            avg   <= mean_full[SAMPLE_W-1:0];
            alert <= above;
        end
    end
endmodule

// File: rtl/movavg_peak_det.sv
// Module: movavg_peak_det (top)
// Averages the last four accepted signed samples using one shared adder over
// four cycles, and raises a registered alert when the mean exceeds thresh.
// Assumes thresh is held steady around completion edges.
module movavg_peak_det #(
    parameter int SAMPLE_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_valid,
    input  logic signed [SAMPLE_W-1:0]  smp_data,
    input  logic signed [SAMPLE_W-1:0]  thresh,
    output logic                        ready,
    output logic signed [SAMPLE_W-1:0]  avg_out,
    output logic                        alert
);
    import pd_pkg::*;

    logic                       accept;
    logic                       acc_clr;
    logic                       acc_add;
    logic                       acc_last;
    logic [IDX_W-1:0]           rd_idx;
    logic signed [SAMPLE_W-1:0] tap_data;

    pd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (smp_valid),
        .ready    (ready),
        .accept   (accept),
        .acc_clr  (acc_clr),
        .acc_add  (acc_add),
        .acc_last (acc_last),
        .rd_idx   (rd_idx)
    );

    pd_window #(.SAMPLE_W(SAMPLE_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (smp_data),
        .rd_idx   (rd_idx),
        .rd_data  (tap_data)
    );

    pd_accum #(.SAMPLE_W(SAMPLE_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .add_en   (acc_add),
        .last     (acc_last),
        .operand  (tap_data),
        .thresh   (thresh),
        .avg      (avg_out),
        .alert    (alert)
    );
endmodule

// File: rtl/movavg_peak_det_chk.sv
// Module: movavg_peak_det_chk
// Checker bound to the top. Watches the handshake timing, the compare and the
// hold behaviour at the ports. The busy length is counted here, not unrolled.
module movavg_peak_det_chk #(
    parameter int SAMPLE_W = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        smp_valid,
    input logic signed [SAMPLE_W-1:0]  smp_data,
    input logic signed [SAMPLE_W-1:0]  thresh,
    input logic                        ready,
    input logic signed [SAMPLE_W-1:0]  avg_out,
    input logic                        alert
);
    logic [3:0] busy_cnt;

    // Purpose: count consecutive cycles with ready low.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (ready)  busy_cnt <= '0;
        else             busy_cnt <= busy_cnt + 1'b1;
    end

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ready) |=> !ready);

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (busy_cnt < 4'd4));

    // R2
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt == 4'd4) |-> ready);

    // R5
    alert_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (alert == ($signed(avg_out) > $signed($past(thresh)))));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> ($stable(avg_out) && $stable(alert)));
endmodule

bind movavg_peak_det movavg_peak_det_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .thresh    (thresh),
    .ready     (ready),
    .avg_out   (avg_out),
    .alert     (alert)
);

// File: tb/movavg_peak_det_tb.sv
// Scoreboard bench: the driver pushes expected averages, the monitor pops them
// when ready rises again and compares.
module movavg_peak_det_tb;
    localparam int SW = 12;

    typedef struct {
        logic signed [SW-1:0] avg;
        logic                 alert;
        string                tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [SW-1:0] smp_data = '0;
    logic signed [SW-1:0] thresh = '0;
    logic                 ready;
    logic signed [SW-1:0] avg_out;
    logic                 alert;

    int   n_checks = 0;
    int   n_errors = 0;
    int   model [4];
    exp_t sb_q [$];
    logic prev_ready = 1'b1;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    movavg_peak_det #(.SAMPLE_W(SW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thresh    (thresh),
        .ready     (ready),
        .avg_out   (avg_out),
        .alert     (alert)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) model[i] = 0;
        prev_ready = 1'b1;
    endtask

    // Driver: accept one sample; optional junk strobe while busy (R7).
    task automatic send(input int s, input bit junk, input string tag);
        int   sum;
        exp_t e;
        int   busy;
        @(negedge clk);
        while (!ready) @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = SW'(s);
        for (int i = 3; i > 0; i--) model[i] = model[i-1];
        model[0] = s;
        sum = model[0] + model[1] + model[2] + model[3];
        e.avg   = SW'(sum >>> 2);
        e.alert = ((sum >>> 2) > int'(thresh));
        e.tag   = tag;
        sb_q.push_back(e);
        @(negedge clk);
        smp_valid = 1'b0;
        busy = 0;
        while (!ready) begin
            busy++;
            if (junk && busy == 2) begin
                smp_valid = 1'b1;
                smp_data  = SW'(12'sh5A5);
            end else begin
                smp_valid = 1'b0;
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        check(busy == 4, "R2 busy cycles", busy, 4);
    endtask

    // Monitor: pop and compare at each rise of ready.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ready && !prev_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(avg_out == e.avg, {e.tag, " avg"}, int'(avg_out), int'(e.avg));
                    check(alert == e.alert, {e.tag, " R5 alert"}, int'(alert), int'(e.alert));
                end
            end
            prev_ready = ready;
        end
    end

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic signed [SW-1:0] held_avg;
        logic                 held_alert;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check(ready == 1'b1, "R1 ready", int'(ready), 1);
        check(avg_out == 0, "R1 avg", int'(avg_out), 0);
        check(alert == 1'b0, "R1 alert", int'(alert), 0);

        // R4 partial window; R3 averaging; R5 equality gives no alert
        thresh = 12'sd150;
        send(100, 1'b0, "R4 first");
        send(200, 1'b0, "R4 second");
        send(300, 1'b0, "R5 equal");
        send(400, 1'b0, "R3 full");
        // R7: junk strobe during busy must not enter window
        send(-5, 1'b1, "R7 junk1");
        send(-600, 1'b1, "R7 junk2");
        thresh = -12'sd100;
        send(-7, 1'b0, "R3 negative");
        send(-9, 1'b0, "R3 floor");

        // R6 hold while idle
        held_avg = avg_out;
        held_alert = alert;
        thresh = 12'sd2000;
        repeat (10) @(negedge clk);
        check(avg_out == held_avg, "R6 avg hold", int'(avg_out), int'(held_avg));
        check(alert == held_alert, "R6 alert hold", int'(alert), int'(held_alert));

        // R8 full-scale positive and negative
        thresh = 12'sd2046;
        for (int i = 0; i < 4; i++) send(2047, 1'b0, "R8 max");
        thresh = 12'sd2047;
        send(2047, 1'b0, "R8 max equal");
        thresh = -12'sd2048;
        for (int i = 0; i < 4; i++) send(-2048, 1'b0, "R8 min");

        // R1 reset clears window: -1 alone floors to -1 (R3, R4)
        do_reset();
        @(negedge clk);
        check(avg_out == 0, "R1 avg after reset", int'(avg_out), 0);
        thresh = -12'sd2;
        send(-1, 1'b0, "R4 floor after reset");
        send(6, 1'b0, "R3 mixed");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R3 all results seen", sb_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule